// File: doc/BRIEF.md
# Serial Transmitter with Sixteenth-Bit Stop Timing

This block serialises characters onto a single output line. Each character is framed by a low start bit and sent least significant bit first, with 5 to 8 data bits and an optional parity bit. The line then returns high for a stop interval. The length of that interval is set in sixteenths of a bit time by a 4-bit code, and the mapping from code to length depends on the character length. Bit timing normally comes from a baud enable that pulses sixteen times per bit. A second mode takes one enable pulse per bit from an external 1x clock. In that mode only whole stop bits can be produced.

A single holding register sits in front of the shift stage. A writer offers a byte with a valid/ready handshake. The byte waits in the holding register until the shift stage is free, so the next character can follow the stop interval of the current one with no idle gap. Frame settings are captured when a character moves into the shift stage. Two status outputs tell the writer whether it may offer a byte and whether the line has gone fully quiet.

Top module: `uart_frac_tx`

## Requirements
- R1: After reset, `txd` is 1, `in_ready` is 1 and `tx_empty` is 1.
- R2: In 16x mode (`cfg_ext_clk`=0), a frame is built as follows:
  - The start bit is 0 and lasts 16 `tick16_en` pulses.
  - The data bits follow, least significant bit first, each lasting 16 pulses.
  - The number of data bits is 5 + `cfg_char_len`: code 0 gives 5 bits and code 3 gives 8 bits.
- R3: When `cfg_par_en`=1, one parity bit follows the last data bit.
  - It is computed only over the configured number of data bits. Bits of `in_data` above that length are ignored.
  - `cfg_par_odd`=0 makes the total count of ones in the data bits plus the parity bit even. `cfg_par_odd`=1 makes that count odd.
- R4: In 16x mode, for 6, 7 or 8 data bits and a stop code n from 0 to 7, the line stays high for 9+n tick pulses after the last data or parity bit.
- R5: In 16x mode, for 5 data bits and a stop code n from 0 to 7, the stop interval is 17+n tick pulses.
- R6: In 16x mode, for a stop code n from 8 to 15, the stop interval is 17+n tick pulses at every character length.
- R7: In 1x mode (`cfg_ext_clk`=1), timing follows `bit1x_en`:
  - Every start, data and parity bit lasts one `bit1x_en` pulse.
  - The stop interval is 1 pulse when bit 3 of the stop code is 0 and 2 pulses when it is 1.
  - `tick16_en` has no effect.
- R8: `in_ready` is 1 exactly when the holding register is empty. A byte is taken on a clock edge with `in_valid` and `in_ready` both high. `in_ready` is 0 in the cycle after that.
- R9: `tx_empty` is 0 from the cycle after a byte is taken until the last stop pulse of the last queued character has been counted. It is 1 otherwise.
- R10: If a byte is waiting when a stop interval ends, its start bit begins on that same edge. The stop interval keeps its exact programmed length.
- R11: While `tx_empty` is 1, `txd` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16_en | input | 1 | Baud enable, 16 pulses per bit time |
| bit1x_en | input | 1 | External 1x enable, one pulse per bit time |
| cfg_ext_clk | input | 1 | 1 selects 1x mode, 0 selects 16x mode |
| cfg_char_len | input | 2 | Data bits minus 5 |
| cfg_par_en | input | 1 | Parity bit enable |
| cfg_par_odd | input | 1 | 1 odd parity, 0 even parity |
| cfg_stop_code | input | 4 | Stop interval code |
| in_data | input | 8 | Byte offered for transmission |
| in_valid | input | 1 | Byte on `in_data` is valid |
| in_ready | output | 1 | Holding register can accept a byte |
| tx_empty | output | 1 | Nothing queued and the line is quiet |
| txd | output | 1 | Serial output, idles high |

## Verification
The bench sweeps all sixteen stop codes across all four character lengths and measures each stop interval in tick pulses. This catches two kinds of error. One is a design that applies the short 9+n mapping to 5-bit characters. The other is a design that applies it to codes 8 and above, and so comes up eight ticks short. Parity is checked with data whose bits above the configured length are set. A design that folds those bits into the parity would flip the parity bit on roughly half of the frames. Back-to-back characters check that a waiting byte starts on the exact edge that ends the stop interval. An off-by-one there would lengthen or shorten the stop interval by one tick. The 1x runs check that whole-bit stop timing is taken from bit 3 alone, so codes 7 and 8 must differ.

// File: rtl/uart_ftx_pkg.sv
package uart_ftx_pkg;

    // Phases of the shift stage, in transmission order
    typedef enum logic [2:0] {
        TX_IDLE,
        TX_START,
        TX_DATA,
        TX_PAR,
        TX_STOP
    } tx_phase_e;

endpackage

// File: rtl/uart_ftx_timing.sv
// Turns the live frame settings into per-bit and stop lengths, counted in step enables.
module uart_ftx_timing #(
    parameter int OVS    = 16,
    parameter int CODE_W = 4,
    parameter int CNT_W  = 6
) (
    input  logic              cfg_ext,
    input  logic [1:0]        cfg_len,
    input  logic [CODE_W-1:0] cfg_code,
    output logic [CNT_W-1:0]  bit_steps,
    output logic [CNT_W-1:0]  stop_steps
);
    localparam int HALF = OVS / 2;

    logic long_stop;

    always_comb begin
        // Upper half of the code, or the shortest character, selects the long table
        long_stop = cfg_code[CODE_W-1] || (cfg_len == 2'd0);
        if (cfg_ext) begin
            bit_steps  = CNT_W'(1);
            stop_steps = cfg_code[CODE_W-1] ? CNT_W'(2) : CNT_W'(1);
        end else begin
            bit_steps  = CNT_W'(OVS);
            stop_steps = CNT_W'(cfg_code)
                       + (long_stop ? CNT_W'(OVS + 1) : CNT_W'(HALF + 1));
        end
    end
endmodule

// File: rtl/uart_ftx_hold.sv
// Single-entry holding register in front of the shift stage.
module uart_ftx_hold #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_valid,
    input  logic              take,
    output logic              full,
    output logic [DATA_W-1:0] data
);
    typedef struct packed {
        logic              full;
        logic [DATA_W-1:0] data;
    } hold_s;

    hold_s h_d, h_q;

    always_comb begin
        h_d = h_q;
        if (take) begin
            h_d.full = 1'b0;
        end else if (in_valid && !h_q.full) begin
            h_d.full = 1'b1;
            h_d.data = in_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) h_q <= '0;
        else        h_q <= h_d;
    end

    assign full = h_q.full;
    assign data = h_q.data;
endmodule

// File: rtl/uart_ftx_serial.sv
// Shift stage: start, data, optional parity, then the programmed stop interval.
module uart_ftx_serial
    import uart_ftx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 6,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic              hold_full,
    input  logic [DATA_W-1:0] hold_data,
    input  logic [CNT_W-1:0]  bit_steps,
    input  logic [CNT_W-1:0]  stop_steps,
    input  logic [IDX_W-1:0]  last_idx,
    input  logic              par_en,
    input  logic              par_odd,
    output logic              take,
    output logic              txd,
    output logic              busy
);
    typedef struct packed {
        tx_phase_e         phase;
        logic [CNT_W-1:0]  cnt;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] shreg;
        logic              par_bit;
        logic              par_on;
        logic              line;
        logic [CNT_W-1:0]  bit_len;
        logic [CNT_W-1:0]  stop_len;
        logic [IDX_W-1:0]  last;
    } ser_s;

    ser_s s_d, s_q;
    logic [DATA_W-1:0] masked;
    logic load, bit_end, stop_end;

    // Bits above the configured length never reach the line or the parity
    always_comb begin
        for (int i = 0; i < DATA_W; i++) begin
            masked[i] = hold_data[i] && (IDX_W'(i) <= last_idx);
        end
    end

    always_comb begin
        s_d      = s_q;
        load     = 1'b0;
        bit_end  = step && (s_q.cnt == s_q.bit_len - CNT_W'(1));
        stop_end = step && (s_q.cnt == s_q.stop_len - CNT_W'(1));
        case (s_q.phase)
            TX_IDLE: begin
                if (hold_full) load = 1'b1;
            end
            TX_START: begin
                if (bit_end) begin
                    s_d.cnt   = '0;
                    s_d.phase = TX_DATA;
                    s_d.idx   = '0;
                    s_d.line  = s_q.shreg[0];
                end else if (step) begin
                    s_d.cnt = s_q.cnt + CNT_W'(1);
                end
            end
            TX_DATA: begin
                if (bit_end) begin
                    s_d.cnt = '0;
                    if (s_q.idx == s_q.last) begin
                        if (s_q.par_on) begin
                            s_d.phase = TX_PAR;
                            s_d.line  = s_q.par_bit;
                        end else begin
                            s_d.phase = TX_STOP;
                            s_d.line  = 1'b1;
                        end
                    end else begin
                        s_d.idx   = s_q.idx + IDX_W'(1);
                        s_d.shreg = s_q.shreg >> 1;
                        s_d.line  = s_q.shreg[1];
                    end
                end else if (step) begin
                    s_d.cnt = s_q.cnt + CNT_W'(1);
                end
            end
            TX_PAR: begin
                if (bit_end) begin
                    s_d.cnt   = '0;
                    s_d.phase = TX_STOP;
                    s_d.line  = 1'b1;
                end else if (step) begin
                    s_d.cnt = s_q.cnt + CNT_W'(1);
                end
            end
            TX_STOP: begin
                if (stop_end) begin
                    s_d.cnt = '0;
                    if (hold_full) load = 1'b1;
                    else           s_d.phase = TX_IDLE;
                end else if (step) begin
                    s_d.cnt = s_q.cnt + CNT_W'(1);
                end
            end
            default: s_d.phase = TX_IDLE;
        endcase

        if (load) begin
            s_d.phase    = TX_START;
            s_d.cnt      = '0;
            s_d.idx      = '0;
            s_d.shreg    = masked;
            s_d.par_bit  = (^masked) ^ par_odd;
            s_d.par_on   = par_en;
            s_d.line     = 1'b0;
            s_d.bit_len  = bit_steps;
            s_d.stop_len = stop_steps;
            s_d.last     = last_idx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.phase <= TX_IDLE;
            s_q.line  <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign take = load;
    assign txd  = s_q.line;
    assign busy = (s_q.phase != TX_IDLE);
endmodule

// File: rtl/uart_frac_tx.sv
module uart_frac_tx #(
    parameter int DATA_W = 8,
    parameter int OVS    = 16,
    parameter int CODE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick16_en,
    input  logic              bit1x_en,
    input  logic              cfg_ext_clk,
    input  logic [1:0]        cfg_char_len,
    input  logic              cfg_par_en,
    input  logic              cfg_par_odd,
    input  logic [CODE_W-1:0] cfg_stop_code,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_valid,
    output logic              in_ready,
    output logic              tx_empty,
    output logic              txd
);
    localparam int CNT_W = $clog2(2 * OVS + 1);
    localparam int IDX_W = $clog2(DATA_W);

    logic              step;
    logic              hold_full, take, busy;
    logic [DATA_W-1:0] hold_data;
    logic [CNT_W-1:0]  bit_steps, stop_steps;
    logic [IDX_W-1:0]  last_idx;

    assign step     = cfg_ext_clk ? bit1x_en : tick16_en;
    assign last_idx = IDX_W'(DATA_W - 4) + IDX_W'(cfg_char_len);

    uart_ftx_timing #(.OVS(OVS), .CODE_W(CODE_W), .CNT_W(CNT_W)) u_timing (
        .cfg_ext    (cfg_ext_clk),
        .cfg_len    (cfg_char_len),
        .cfg_code   (cfg_stop_code),
        .bit_steps  (bit_steps),
        .stop_steps (stop_steps)
    );

    uart_ftx_hold #(.DATA_W(DATA_W)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_data  (in_data),
        .in_valid (in_valid),
        .take     (take),
        .full     (hold_full),
        .data     (hold_data)
    );

    uart_ftx_serial #(.DATA_W(DATA_W), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_serial (
        .clk        (clk),
        .rst_n      (rst_n),
        .step       (step),
        .hold_full  (hold_full),
        .hold_data  (hold_data),
        .bit_steps  (bit_steps),
        .stop_steps (stop_steps),
        .last_idx   (last_idx),
        .par_en     (cfg_par_en),
        .par_odd    (cfg_par_odd),
        .take       (take),
        .txd        (txd),
        .busy       (busy)
    );

    assign in_ready = !hold_full;
    assign tx_empty = !hold_full && !busy;
endmodule

// File: rtl/uart_frac_tx_chk.sv
module uart_frac_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic in_valid,
    input logic in_ready,
    input logic tx_empty,
    input logic txd
);
    // R8 / R9: a taken byte occupies the holding register and the block is no longer empty
    p_accept_fills_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (!in_ready && !tx_empty));

    // R11: a quiet block keeps the line high
    p_empty_line_high_r11: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty |-> txd);

    // R9: an empty block always has room in the holding register
    p_empty_has_room_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty |-> in_ready);

    // R2: a start bit only begins while a character is in flight
    p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(txd) |-> !tx_empty);
endmodule

bind uart_frac_tx uart_frac_tx_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .tx_empty (tx_empty),
    .txd      (txd)
);

// File: tb/sim_uart_frac_tx.sv
`timescale 1ns/1ps
module sim_uart_frac_tx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16_en = 1'b0;
    logic       bit1x_en = 1'b0;
    logic       cfg_ext_clk = 1'b0;
    logic [1:0] cfg_char_len = 2'd3;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_odd = 1'b0;
    logic [3:0] cfg_stop_code = 4'd0;
    logic [7:0] in_data = 8'd0;
    logic       in_valid = 1'b0;
    logic       in_ready, tx_empty, txd;

    int nchk = 0;
    int nerr = 0;
    int cyc = 0;
    bit pending = 1'b0;
    int tdiv = 0;
    int ediv = 0;

    always #4 clk = ~clk;  // 125 MHz

    uart_frac_tx u0 (
        .clk(clk), .rst_n(rst_n), .tick16_en(tick16_en), .bit1x_en(bit1x_en),
        .cfg_ext_clk(cfg_ext_clk), .cfg_char_len(cfg_char_len),
        .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .cfg_stop_code(cfg_stop_code), .in_data(in_data), .in_valid(in_valid),
        .in_ready(in_ready), .tx_empty(tx_empty), .txd(txd)
    );

    // Enable generators: 16x pulse every 3 cycles, 1x pulse every 5 cycles
    always @(posedge clk) begin
        tdiv      <= (tdiv == 2) ? 0 : tdiv + 1;
        tick16_en <= (tdiv == 2);
        ediv      <= (ediv == 4) ? 0 : ediv + 1;
        bit1x_en  <= (ediv == 4);
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 190000) begin
            nerr = nerr + 1;
            nchk = nchk + 1;
            $display("FAIL watchdog: run hung, got %0d cycles expected fewer", cyc);
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        nchk = nchk + 1;
        if (!ok) begin
            nerr = nerr + 1;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic bit step_now();
        return cfg_ext_clk ? bit1x_en : tick16_en;
    endfunction

    task automatic next_step();
        do @(negedge clk); while (!step_now());
    endtask

    function automatic int exp_stop(input int nbits, input int code, input bit ext);
        if (ext) return (code >= 8) ? 2 : 1;
        if (code >= 8 || nbits == 5) return 17 + code;
        return 9 + code;
    endfunction

    task automatic send(input logic [7:0] d);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_data  = d;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk(in_ready == 1'b0, "R8", "in_ready after byte taken", int'(in_ready), 0);
    endtask

    task automatic check_frame(input logic [7:0] d, input int nbits, input bit pe,
                               input bit po, input int code, input bit ext);
        int L = ext ? 1 : 16;
        int S = exp_stop(nbits, code, ext);
        int nb = 1 + nbits + (pe ? 1 : 0);
        bit ebits[10];
        int ones = 0;
        int cnt = 0;
        bit next_start = 1'b0;
        string sreq;
        ebits[0] = 1'b0;
        for (int i = 0; i < nbits; i++) begin
            ebits[1 + i] = d[i];
            ones += d[i];
        end
        if (pe) ebits[1 + nbits] = (ones % 2 == 1) ^ po;
        if (!pending) begin
            do next_step(); while (txd !== 1'b0);
        end
        pending = 1'b0;
        chk(tx_empty == 1'b0, "R9", "tx_empty during start bit", int'(tx_empty), 0);
        for (int b = 0; b < nb; b++) begin
            int bad = 0;
            for (int s = 0; s < L; s++) begin
                if (!(b == 0 && s == 0)) next_step();
                if (txd !== ebits[b]) bad++;
            end
            if (b == 0)
                chk(bad == 0, ext ? "R7" : "R2", "start bit low samples wrong", bad, 0);
            else if (b <= nbits)
                chk(bad == 0, ext ? "R7" : "R2", $sformatf("data bit %0d of 0x%02h", b - 1, d),
                    int'(txd), int'(ebits[b]));
            else
                chk(bad == 0, "R3", $sformatf("parity of 0x%02h len %0d odd %0d", d, nbits, po),
                    int'(txd), int'(ebits[b]));
        end
        forever begin
            @(negedge clk);
            if (tx_empty) break;
            if (step_now()) begin
                if (txd === 1'b0) begin
                    next_start = 1'b1;
                    break;
                end
                cnt++;
            end
        end
        pending = next_start;
        if (ext)              sreq = "R7";
        else if (code >= 8)   sreq = "R6";
        else if (nbits == 5)  sreq = "R5";
        else                  sreq = "R4";
        if (next_start) sreq = {sreq, "/R10"};
        chk(cnt == S, sreq, $sformatf("stop ticks len %0d code %0d", nbits, code), cnt, S);
    endtask

    task automatic set_cfg(input int nbits, input bit pe, input bit po,
                           input int code, input bit ext);
        @(negedge clk);
        cfg_char_len  = 2'(nbits - 5);
        cfg_par_en    = pe;
        cfg_par_odd   = po;
        cfg_stop_code = 4'(code);
        cfg_ext_clk   = ext;
    endtask

    task automatic idle_check();
        int bad = 0;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            if (txd !== 1'b1 || tx_empty !== 1'b1) bad++;
        end
        chk(bad == 0, "R11", "line high and empty after frame", bad, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(txd == 1'b1, "R1", "txd after reset", int'(txd), 1);
        chk(in_ready == 1'b1, "R1", "in_ready after reset", int'(in_ready), 1);
        chk(tx_empty == 1'b1, "R1", "tx_empty after reset", int'(tx_empty), 1);

        // 16x sweep: every length and every stop code, parity varied
        for (int nbits = 5; nbits <= 8; nbits++) begin
            for (int code = 0; code < 16; code++) begin
                bit pe = (code % 3) != 0;
                bit po = (code % 3) == 2;
                logic [7:0] d = 8'((nbits * 16 + code) * 37 + 5);
                set_cfg(nbits, pe, po, code, 1'b0);
                send(d);
                check_frame(d, nbits, pe, po, code, 1'b0);
                idle_check();
            end
        end

        // 1x mode: stop length depends on bit 3 only
        for (int nbits = 5; nbits <= 8; nbits++) begin
            for (int k = 0; k < 4; k++) begin
                int code = (k == 0) ? 0 : (k == 1) ? 7 : (k == 2) ? 8 : 15;
                logic [7:0] d = 8'(nbits * 29 + k * 71);
                set_cfg(nbits, 1'b1, 1'(nbits % 2), code, 1'b1);
                send(d);
                check_frame(d, nbits, 1'b1, 1'(nbits % 2), code, 1'b1);
                idle_check();
            end
        end

        // Back-to-back characters, R10
        set_cfg(8, 1'b0, 1'b0, 0, 1'b0);
        send(8'hA5);
        fork
            send(8'h3C);
            check_frame(8'hA5, 8, 1'b0, 1'b0, 0, 1'b0);
        join
        check_frame(8'h3C, 8, 1'b0, 1'b0, 0, 1'b0);
        idle_check();

        set_cfg(5, 1'b1, 1'b1, 3, 1'b0);
        send(8'hE6);
        fork
            send(8'h19);
            check_frame(8'hE6, 5, 1'b1, 1'b1, 3, 1'b0);
        join
        check_frame(8'h19, 5, 1'b1, 1'b1, 3, 1'b0);
        idle_check();

        set_cfg(6, 1'b0, 1'b0, 8, 1'b1);
        send(8'h2B);
        fork
            send(8'h14);
            check_frame(8'h2B, 6, 1'b0, 1'b0, 8, 1'b1);
        join
        check_frame(8'h14, 6, 1'b0, 1'b0, 8, 1'b1);
        idle_check();

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule